// File: doc/BRIEF.md
# Bridge Primary-Side Status Register

This block holds the 16-bit status word for the upstream side of a bus-to-bus bridge. Configuration software reads it to learn two things: what the upstream interface can do, and which error conditions have occurred there since the last time software cleared them.

Four fields are fixed at elaboration through parameters:
- a capability-list flag;
- a 66 MHz capability flag;
- a flag for fast back-to-back decoding across different targets;
- a two-bit code for the target-select response speed.

Six error flags are sticky. Each one is set by one-cycle event pulses from the bridge's master and target engines, and some of them are qualified by the parity-response enable taken from the command register. Software clears a flag by writing a 1 to its position.

Writes come through a configuration port that has a write strobe, 16 data bits and two byte enables. Read data is a combinational view of the register state, so it shows what the last clock edge stored. Reading the register changes nothing.

Top module: `brg_pri_status`

## Requirements
- R1: Bits 3:0 and bit 6 always read 0, and no write changes them.
- R2: Bit 4 reads `HAS_CAP_LIST`, bit 5 reads `CAP_66MHZ` and bit 7 reads `FBB_DIFF_TGT`, and no write changes them.
- R3: Bits 10:9 read `DEVSEL_SPEED`, where 00 is fast, 01 medium and 10 slow. The value 11 is rejected at elaboration.
- R4: Bit 8 (master data parity error) sets on the edge after a cycle in which `perr_resp_en` is 1 and either `mst_rd_perr_drv` or `mst_wr_perr_seen` is 1. When `perr_resp_en` is 0 these pulses leave bit 8 unchanged.
- R5: On the edge after a pulse, a flag sets as follows:
  - bit 11 sets after `tgt_abort_sent`;
  - bit 12 sets after `mst_tabort_rcvd`;
  - bit 13 sets after `mst_mabort_rcvd`;
  - bit 14 sets after `serr_driven`.
- R6: Bit 15 sets on the edge after any of `tgt_addr_perr`, `tgt_wr_data_perr` or `mst_rd_data_perr`, whatever the value of `perr_resp_en`.
- R7: While `rst_n` is 0, bits 8 and 15:11 read 0.
- R8: A set sticky bit stays 1 until a write carries a 1 in its position with byte enable 1 active, which clears it on the next edge. Writing a 0 leaves the bit unchanged.
- R9: `cfg_wr_be[0]` gates bits 7:0 and `cfg_wr_be[1]` gates bits 15:8. A write with only `cfg_wr_be[0]` active clears no sticky bit.
- R10: When a set event and a clearing write hit the same bit in the same cycle, the bit reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 16 | Write data (1 clears a sticky bit) |
| cfg_wr_be | input | 2 | Byte enables, bit 0 for the low byte |
| perr_resp_en | input | 1 | Parity error response enable from the command register |
| mst_rd_perr_drv | input | 1 | As master, bridge drove the parity-error signal on a read |
| mst_wr_perr_seen | input | 1 | As master, bridge saw the parity-error signal on a write |
| tgt_abort_sent | input | 1 | As target, bridge signalled target abort |
| mst_tabort_rcvd | input | 1 | As master, bridge received target abort |
| mst_mabort_rcvd | input | 1 | As master, bridge saw master abort |
| serr_driven | input | 1 | Bridge drove the system-error signal |
| tgt_addr_perr | input | 1 | Address parity error seen as a potential target |
| tgt_wr_data_perr | input | 1 | Data parity error as target of a write |
| mst_rd_data_perr | input | 1 | Data parity error as master of a read |
| rd_data | output | 16 | Status register read value |

## Verification
The bench builds the block with `HAS_CAP_LIST=0`, `CAP_66MHZ=1`, `FBB_DIFF_TGT=1` and `DEVSEL_SPEED=2'b10`. These values differ from the defaults in the capability and fast back-to-back flags and select the slow speed code, so a field that ignores its parameter or sits at the wrong bit position produces a visible mismatch. Event pulses are sparse enough that flags can both accumulate and be cleared by random writes. Directed cycles force the same-cycle set-and-clear race and the write that enables only the low byte.

// File: rtl/brg_stat_pkg.sv
package brg_stat_pkg;
  localparam int STAT_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int NUM_BE  = STAT_W / BYTE_W;

  localparam int B_CAP    = 4;
  localparam int B_66M    = 5;
  localparam int B_FBB    = 7;
  localparam int B_MDPE   = 8;
  localparam int B_DSEL   = 9;
  localparam int B_STA    = 11;
  localparam int B_RTA    = 12;
  localparam int B_RMA    = 13;
  localparam int B_SSE    = 14;
  localparam int B_DPE    = 15;

  localparam logic [STAT_W-1:0] STICKY_MASK =
    (STAT_W'(1) << B_MDPE) | (STAT_W'(1) << B_STA) | (STAT_W'(1) << B_RTA) |
    (STAT_W'(1) << B_RMA)  | (STAT_W'(1) << B_SSE) | (STAT_W'(1) << B_DPE);

  typedef struct packed {
    logic mst_rd_perr_drv;
    logic mst_wr_perr_seen;
    logic tgt_abort_sent;
    logic mst_tabort_rcvd;
    logic mst_mabort_rcvd;
    logic serr_driven;
    logic tgt_addr_perr;
    logic tgt_wr_data_perr;
    logic mst_rd_data_perr;
  } brg_evt_t;

  function automatic logic [STAT_W-1:0] fixed_word(input logic cap, input logic f66,
                                                   input logic fbb, input logic [1:0] dsel);
    logic [STAT_W-1:0] w;
    w = '0;
    w[B_CAP]          = cap;
    w[B_66M]          = f66;
    w[B_FBB]          = fbb;
    w[B_DSEL+1:B_DSEL] = dsel;
    return w;
  endfunction
endpackage

// File: rtl/brg_stat_setq.sv
module brg_stat_setq
  import brg_stat_pkg::*;
(
  input  brg_evt_t          evt,
  input  logic              perr_resp_en,
  output logic [STAT_W-1:0] set_vec
);
  always_comb begin
    set_vec         = '0;
    set_vec[B_MDPE] = perr_resp_en & (evt.mst_rd_perr_drv | evt.mst_wr_perr_seen);
    set_vec[B_STA]  = evt.tgt_abort_sent;
    set_vec[B_RTA]  = evt.mst_tabort_rcvd;
    set_vec[B_RMA]  = evt.mst_mabort_rcvd;
    set_vec[B_SSE]  = evt.serr_driven;
    set_vec[B_DPE]  = evt.tgt_addr_perr | evt.tgt_wr_data_perr | evt.mst_rd_data_perr;
  end
endmodule

// File: rtl/brg_stat_w1c.sv
module brg_stat_w1c
  import brg_stat_pkg::*;
(
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic [NUM_BE-1:0] wr_be,
  output logic [STAT_W-1:0] clr_vec
);
  for (genvar b = 0; b < NUM_BE; b++) begin : g_lane
    assign clr_vec[b*BYTE_W +: BYTE_W] =
      wr_data[b*BYTE_W +: BYTE_W] & {BYTE_W{wr_en & wr_be[b]}};
  end
endmodule

// File: rtl/brg_stat_flag.sv
module brg_stat_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_nxt;
  logic q_en;

  always_comb begin
    q_en  = set_i | clr_i;
    q_nxt = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (q_en)  q_o <= q_nxt;
  end
endmodule

// File: rtl/brg_pri_status.sv
module brg_pri_status
  import brg_stat_pkg::*;
#(
  parameter logic       HAS_CAP_LIST = 1'b1,
  parameter logic       CAP_66MHZ    = 1'b1,
  parameter logic       FBB_DIFF_TGT = 1'b0,
  parameter logic [1:0] DEVSEL_SPEED = 2'b01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic [15:0] cfg_wr_data,
  input  logic [1:0]  cfg_wr_be,
  input  logic        perr_resp_en,
  input  logic        mst_rd_perr_drv,
  input  logic        mst_wr_perr_seen,
  input  logic        tgt_abort_sent,
  input  logic        mst_tabort_rcvd,
  input  logic        mst_mabort_rcvd,
  input  logic        serr_driven,
  input  logic        tgt_addr_perr,
  input  logic        tgt_wr_data_perr,
  input  logic        mst_rd_data_perr,
  output logic [15:0] rd_data
);
  localparam logic [STAT_W-1:0] FIXED = fixed_word(HAS_CAP_LIST, CAP_66MHZ,
                                                   FBB_DIFF_TGT, DEVSEL_SPEED);

  if (DEVSEL_SPEED == 2'b11) begin : g_bad_dsel
    $error("DEVSEL_SPEED value 2'b11 is reserved");
  end

  brg_evt_t          evt;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] stat_bits;
  logic [STAT_W-1:0] unused_bits;

  always_comb begin
    evt.mst_rd_perr_drv  = mst_rd_perr_drv;
    evt.mst_wr_perr_seen = mst_wr_perr_seen;
    evt.tgt_abort_sent   = tgt_abort_sent;
    evt.mst_tabort_rcvd  = mst_tabort_rcvd;
    evt.mst_mabort_rcvd  = mst_mabort_rcvd;
    evt.serr_driven      = serr_driven;
    evt.tgt_addr_perr    = tgt_addr_perr;
    evt.tgt_wr_data_perr = tgt_wr_data_perr;
    evt.mst_rd_data_perr = mst_rd_data_perr;
  end

  brg_stat_setq u_setq (
    .evt          (evt),
    .perr_resp_en (perr_resp_en),
    .set_vec      (set_vec)
  );

  brg_stat_w1c u_w1c (
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .wr_be   (cfg_wr_be),
    .clr_vec (clr_vec)
  );

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (STICKY_MASK[i]) begin : g_sticky
      brg_stat_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec[i]),
        .clr_i (clr_vec[i]),
        .q_o   (stat_bits[i])
      );
      assign unused_bits[i] = 1'b0;
    end else begin : g_fixed
      assign stat_bits[i]   = FIXED[i];
      assign unused_bits[i] = set_vec[i] ^ clr_vec[i];
    end
  end

  assign rd_data = stat_bits;
endmodule

// File: rtl/brg_pri_status_chk.sv
module brg_pri_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_en,
  input logic [15:0] cfg_wr_data,
  input logic [1:0]  cfg_wr_be,
  input logic        perr_resp_en,
  input logic        mst_rd_perr_drv,
  input logic        mst_wr_perr_seen,
  input logic        tgt_abort_sent,
  input logic        mst_tabort_rcvd,
  input logic        mst_mabort_rcvd,
  input logic        serr_driven,
  input logic        tgt_addr_perr,
  input logic        tgt_wr_data_perr,
  input logic        mst_rd_data_perr,
  input logic [15:0] rd_data
);
  logic [15:0] hi_clr;
  assign hi_clr = (cfg_wr_en && cfg_wr_be[1]) ? {cfg_wr_data[15:8], 8'h00} : 16'h0000;

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3:0] == 4'h0 && rd_data[6] == 1'b0);

  a_r2_fixed_stable: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> $stable({rd_data[10:9], rd_data[7], rd_data[5:4]}));

  a_r4_mdpe_set: assert property (@(posedge clk) disable iff (!rst_n)
    perr_resp_en && (mst_rd_perr_drv || mst_wr_perr_seen) |=> rd_data[8]);

  a_r4_mdpe_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_resp_en && !rd_data[8] |=> !rd_data[8]);

  a_r5_sta_set: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_abort_sent |=> rd_data[11]);

  a_r5_rma_set: assert property (@(posedge clk) disable iff (!rst_n)
    mst_mabort_rcvd |=> rd_data[13]);

  a_r6_dpe_set: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_addr_perr || tgt_wr_data_perr || mst_rd_data_perr |=> rd_data[15]);

  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_data & ($past(rd_data) & ~$past(hi_clr))) ==
              ($past(rd_data) & ~$past(hi_clr))));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en && cfg_wr_be[1] && cfg_wr_data[12] && !mst_tabort_rcvd |=> !rd_data[12]);

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    serr_driven && hi_clr[14] |=> rd_data[14]);
endmodule

bind brg_pri_status brg_pri_status_chk u_chk (.*);

// File: tb/test_brg_pri_status.sv
module test_brg_pri_status;
  localparam logic [15:0] FIXED_EXP = 16'h04A0;
  localparam logic [15:0] STICKY    = 16'hF900;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [15:0] cfg_wr_data;
  logic [1:0]  cfg_wr_be;
  logic        perr_resp_en;
  logic [8:0]  ev;
  logic [15:0] rd_data;
  logic [15:0] model;
  int          checks = 0;
  int          errors = 0;
  bit          done   = 1'b0;

  always #5 clk = ~clk;

  brg_pri_status #(
    .HAS_CAP_LIST (1'b0),
    .CAP_66MHZ    (1'b1),
    .FBB_DIFF_TGT (1'b1),
    .DEVSEL_SPEED (2'b10)
  ) i_brg_pri_status (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_wr_en        (cfg_wr_en),
    .cfg_wr_data      (cfg_wr_data),
    .cfg_wr_be        (cfg_wr_be),
    .perr_resp_en     (perr_resp_en),
    .mst_rd_perr_drv  (ev[0]),
    .mst_wr_perr_seen (ev[1]),
    .tgt_abort_sent   (ev[2]),
    .mst_tabort_rcvd  (ev[3]),
    .mst_mabort_rcvd  (ev[4]),
    .serr_driven      (ev[5]),
    .tgt_addr_perr    (ev[6]),
    .tgt_wr_data_perr (ev[7]),
    .mst_rd_data_perr (ev[8]),
    .rd_data          (rd_data)
  );

  function automatic logic [15:0] next_val(input logic [15:0] cur, input logic [8:0] e,
      input logic pre, input logic we, input logic [15:0] wd, input logic [1:0] be);
    logic [15:0] s, c;
    s = '0;
    s[8]  = pre & (e[0] | e[1]);
    s[11] = e[2];
    s[12] = e[3];
    s[13] = e[4];
    s[14] = e[5];
    s[15] = e[6] | e[7] | e[8];
    c = we ? {be[1] ? wd[15:8] : 8'h00, be[0] ? wd[7:0] : 8'h00} : 16'h0000;
    return (((cur & ~c) | s) & STICKY) | FIXED_EXP;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic [8:0] e, input logic pre,
                      input logic we, input logic [15:0] wd, input logic [1:0] be);
    ev = e; perr_resp_en = pre; cfg_wr_en = we; cfg_wr_data = wd; cfg_wr_be = be;
    model = next_val(model, e, pre, we, wd, be);
    @(posedge clk);
    @(negedge clk);
    ev = '0; cfg_wr_en = 1'b0;
    chk(req, rd_data, model);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0; cfg_wr_be = '0;
    perr_resp_en = 1'b0; ev = '0;
    model = FIXED_EXP;
    repeat (3) @(negedge clk);
    chk("R7 reset value", rd_data, FIXED_EXP);
    chk("R1 reserved zero", rd_data & 16'h004F, 16'h0000);
    chk("R2 capability bits", rd_data & 16'h00B0, 16'h00A0);
    chk("R3 speed code", {14'h0, rd_data[10:9]}, 16'h0002);
    rst_n = 1'b1;
    @(negedge clk);

    step("R4 gated by enable", 9'h003, 1'b0, 1'b0, 16'h0, 2'b00);
    step("R4 mdpe set", 9'h001, 1'b1, 1'b0, 16'h0, 2'b00);
    step("R5 target abort sent", 9'h004, 1'b0, 1'b0, 16'h0, 2'b00);
    step("R5 aborts and serr", 9'h038, 1'b0, 1'b0, 16'h0, 2'b00);
    step("R8 write zero keeps", 9'h000, 1'b0, 1'b1, 16'h0000, 2'b11);
    step("R9 low lane only", 9'h000, 1'b0, 1'b1, 16'hFFFF, 2'b01);
    step("R1 R2 write ones", 9'h000, 1'b0, 1'b1, 16'h06FF, 2'b11);
    step("R8 clear all", 9'h000, 1'b0, 1'b1, 16'hFFFF, 2'b10);
    step("R6 dpe no enable", 9'h040, 1'b0, 1'b0, 16'h0, 2'b00);
    step("R10 set beats clear", 9'h100, 1'b0, 1'b1, 16'h8000, 2'b10);
    step("R8 clear dpe", 9'h000, 1'b0, 1'b1, 16'h8000, 2'b10);
    step("R6 write data perr", 9'h080, 1'b1, 1'b0, 16'h0, 2'b00);

    for (int n = 0; n < 400; n++) begin
      logic [8:0] e;
      for (int k = 0; k < 9; k++) e[k] = ($urandom % 8) == 0;
      step("R8 random mix", e, 1'($urandom), ($urandom % 3) == 0,
           16'($urandom), 2'($urandom));
    end

    rst_n = 1'b0;
    model = FIXED_EXP;
    #1;
    chk("R7 async reset", rd_data, FIXED_EXP);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule